// File: doc/BRIEF.md
# Selectable Synchronous Clock Divider Bank

This block takes one input clock and derives two groups of output clocks from it. Both groups are driven by registers on a single gated copy of the input clock, so any edge that two outputs share happens on the same input rising edge. Group A runs at the input rate or at half of it. Group B runs at one half, one third, one quarter or one sixth of the input rate. Two static select inputs choose the ratios together: a "fast" select picks between the {1, 2/3} set and the {2, 4/6} set, and an "odd" select picks the odd or even member of the group B pair.

A hold input freezes every output at its present level. The hold is captured by a flip-flop on the falling edge of the input clock, so the internal clock is switched on or off only while it is low, and the dividers never see a shortened pulse. A master reset, asynchronous and active high, forces all outputs low and clears every divider phase. Several instances released from reset on the same edge therefore stay aligned with each other.

Top module: `cdb_div_bank`

## Requirements
- R1: While `rst_i` is high, every bit of `grp_a_o` and `grp_b_o` is 0, whatever the clock and `hold_i` do; an assertion of `rst_i` takes effect at once, without waiting for a clock edge.
- R2: On the first input rising edge after reset release whose preceding falling edge sampled `hold_i` low, every output bit goes high on that same edge.
- R3: With `fast_i` = 0, group A toggles on every effective rising edge (divide by 2, one input period high, one low).
- R4: With `fast_i` = 0, group B divides by 4 (two periods high, two low) when `odd_i` = 0, and by 6 (three high, three low) when `odd_i` = 1.
- R5: With `fast_i` = 1, group A follows the gated input clock: high while the input clock is high and the gate is open, low otherwise.
- R6: With `fast_i` = 1, group B divides by 2 when `odd_i` = 0, and by 3 when `odd_i` = 1, high for one input period and low for two.
- R7: `hold_i` is sampled on each falling input edge; a sampled 1 blocks the following rising edge, so all outputs keep their levels and every divider phase stays put; once the hold is released, each sequence resumes from where it stopped.
- R8: Toggling `hold_i` at any time never produces an output high or low pulse shorter than half an input period.
- R9: All divider outputs change only on input rising edges, all copies in a group are identical, and whenever every divider phase is zero, the next effective edge drives both groups high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; dividers advance on its rising edge |
| rst_i | input | 1 | Asynchronous master reset, active high |
| hold_i | input | 1 | Freeze request, sampled on the falling input edge |
| fast_i | input | 1 | Ratio set select: 1 picks {1, 2/3}, 0 picks {2, 4/6}; change only during reset |
| odd_i | input | 1 | Group B select: 1 picks 3 or 6, 0 picks 2 or 4; change only during reset |
| grp_a_o | output | NUM_A | Group A clock copies |
| grp_b_o | output | NUM_B | Group B clock copies |

## Verification
The bench builds the block with two group A copies and three group B copies, so the replication loops run with unequal widths and every copy is compared against the same expected level. All four select combinations are driven after a reset, which brings the divide-by-1 pass-through, the odd divide-by-3 duty cycle and the common start edge within reach. Hold is toggled at varying offsets in both clock phases, so the bench can track the falling-edge capture edge by edge and measure every pulse width of the pass-through output.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

  // Largest division ratio any group can select.
  localparam int MAX_RATIO = 6;
  // Counter wide enough to hold the ratio value itself.
  localparam int CNT_W = $clog2(MAX_RATIO + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  // Group A ratio: pass-through in fast mode, halving otherwise.
  function automatic cnt_t ratio_grp_a(logic fast);
    return fast ? cnt_t'(1) : cnt_t'(2);
  endfunction

  // Group B ratio, chosen jointly by both selects.
  function automatic cnt_t ratio_grp_b(logic fast, logic odd);
    cnt_t r;
    unique case ({fast, odd})
      2'b00:   r = cnt_t'(4);
      2'b01:   r = cnt_t'(6);
      2'b10:   r = cnt_t'(2);
      default: r = cnt_t'(3);
    endcase
    return r;
  endfunction

  // Number of input periods an output stays high within one divided period.
  // Even ratios give half; odd ratios above one round down; ratio one is high.
  function automatic cnt_t high_span(cnt_t r);
    cnt_t h;
    if (r <= cnt_t'(1)) h = cnt_t'(1);
    else if (r[0])      h = cnt_t'((r - cnt_t'(1)) >> 1);
    else                h = cnt_t'(r >> 1);
    return h;
  endfunction

endpackage

// File: rtl/cdb_clk_gate.sv
module cdb_clk_gate (
  input  logic clk_i,
  input  logic hold_i,
  output logic run_o,
  output logic clk_g_o
);

  logic run_q;

  // Capture on the falling edge: the gate only moves while the clock is low.
  always_ff @(negedge clk_i) begin
    run_q <= ~hold_i;
  end

  assign run_o   = run_q;
  assign clk_g_o = clk_i & run_q;

endmodule

// File: rtl/cdb_div_cell.sv
module cdb_div_cell
  import cdb_pkg::*;
(
  input  logic clk_g,
  input  logic rst_i,
  input  cnt_t ratio_i,
  input  cnt_t high_i,
  output cnt_t phase_o,
  output logic q_o
);

  cnt_t phase_q;
  logic q_q;
  logic wrap_w;

  // Wrap point; >= keeps the counter bounded even if the ratio moved.
  assign wrap_w = (phase_q >= cnt_t'(ratio_i - cnt_t'(1)));

  always_ff @(posedge clk_g or posedge rst_i) begin
    if (rst_i) begin
      phase_q <= '0;
      q_q     <= 1'b0;
    end else begin
      q_q     <= (phase_q < high_i);
      phase_q <= wrap_w ? '0 : cnt_t'(phase_q + cnt_t'(1));
    end
  end

  assign phase_o = phase_q;
  assign q_o     = q_q;

  // R4
  phase_range_chk: assert property (@(posedge clk_g) disable iff (rst_i)
    phase_q < ratio_i);

  // R2
  lead_edge_chk: assert property (@(posedge clk_g) disable iff (rst_i)
    (phase_q == '0) |=> q_q);

endmodule

// File: rtl/cdb_div_bank.sv
module cdb_div_bank
  import cdb_pkg::*;
#(
  parameter int NUM_A = 2,
  parameter int NUM_B = 2
) (
  input  logic             clk_in,
  input  logic             rst_i,
  input  logic             hold_i,
  input  logic             fast_i,
  input  logic             odd_i,
  output logic [NUM_A-1:0] grp_a_o,
  output logic [NUM_B-1:0] grp_b_o
);

  logic run_w;
  logic gclk_w;
  cnt_t a_ratio, b_ratio;
  cnt_t a_high, b_high;
  cnt_t a_cnt, b_cnt;
  logic a_q, b_q;
  logic a_src;

  assign a_ratio = ratio_grp_a(fast_i);
  assign b_ratio = ratio_grp_b(fast_i, odd_i);
  assign a_high  = high_span(a_ratio);
  assign b_high  = high_span(b_ratio);

  cdb_clk_gate u_gate (
    .clk_i  (clk_in),
    .hold_i (hold_i),
    .run_o  (run_w),
    .clk_g_o(gclk_w)
  );

  cdb_div_cell u_div_a (
    .clk_g  (gclk_w),
    .rst_i  (rst_i),
    .ratio_i(a_ratio),
    .high_i (a_high),
    .phase_o(a_cnt),
    .q_o    (a_q)
  );

  cdb_div_cell u_div_b (
    .clk_g  (gclk_w),
    .rst_i  (rst_i),
    .ratio_i(b_ratio),
    .high_i (b_high),
    .phase_o(b_cnt),
    .q_o    (b_q)
  );

  // Ratio one passes the gated clock itself; reset still forces it low.
  assign a_src = (a_ratio == cnt_t'(1)) ? (gclk_w & ~rst_i) : a_q;

  for (genvar i = 0; i < NUM_A; i++) begin : g_copy_a
    assign grp_a_o[i] = a_src;
  end

  for (genvar j = 0; j < NUM_B; j++) begin : g_copy_b
    assign grp_b_o[j] = b_q;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_in)
    rst_i |-> (grp_a_o == '0 && grp_b_o == '0));

  // R7
  stall_chk: assert property (@(posedge clk_in) disable iff (rst_i)
    !run_w |=> ($stable(a_cnt) && $stable(b_cnt) && $stable(b_q)));

  // R9
  common_rise_chk: assert property (@(posedge clk_in) disable iff (rst_i)
    (run_w && a_cnt == '0 && b_cnt == '0) |=> (a_q && b_q));

endmodule

// File: tb/test_cdb_div_bank.sv
`timescale 1ns/1ps
module test_cdb_div_bank;

  localparam int NA = 2;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold = 1'b0;
  logic fast = 1'b0;
  logic odd = 1'b0;
  logic [NA-1:0] ga;
  logic [NB-1:0] gb;

  int n_run = 0;
  int n_fail = 0;
  bit run_m = 1'b0;
  int eff = 0;
  bit mon_on = 1'b0;
  int runts = 0;
  realtime t_edge = 0.0;

  // 50 MHz
  always #10 clk = ~clk;

  // Bench model of the falling-edge gate
  always @(negedge clk) run_m = !hold;

  // Pulse width monitor on the first group A copy
  always @(ga[0]) begin
    if (mon_on && (($realtime - t_edge) < 9.9)) runts++;
    t_edge = $realtime;
  end

  cdb_div_bank #(.NUM_A(NA), .NUM_B(NB)) i_cdb_div_bank (
    .clk_in (clk),
    .rst_i  (rst),
    .hold_i (hold),
    .fast_i (fast),
    .odd_i  (odd),
    .grp_a_o(ga),
    .grp_b_o(gb)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int ratio_b(bit f, bit o);
    if (f) return o ? 3 : 2;
    return o ? 6 : 4;
  endfunction

  function automatic int hi_len(int n);
    return (n == 1) ? 1 : n / 2;
  endfunction

  function automatic bit exp_lvl(int n, int e);
    if (e == 0) return 1'b0;
    return ((e - 1) % n) < hi_len(n);
  endfunction

  task automatic start(bit f, bit o);
    hold = 1'b0;
    rst  = 1'b1;
    fast = f;
    odd  = o;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #5;
    rst = 1'b0;
    eff = 0;
  endtask

  // Called at rising edge + 5 ns
  task automatic check_outputs(string tag);
    bit ea, eb;
    ea = fast ? run_m : exp_lvl(2, eff);
    eb = exp_lvl(ratio_b(fast, odd), eff);
    check(ga == {NA{ea}}, tag, int'(ga), ea ? (1 << NA) - 1 : 0);
    check(gb == {NB{eb}}, tag, int'(gb), eb ? (1 << NB) - 1 : 0);
  endtask

  task automatic t_modes(bit f, bit o, string tag);
    logic [NA-1:0] pa;
    logic [NB-1:0] pb;
    start(f, o);
    for (int k = 1; k <= 24; k++) begin
      @(posedge clk);
      #5;
      if (run_m) eff++;
      check_outputs(tag);
      if (k == 1)
        check(ga == '1 && gb == '1, "R2 common first edge", int'({ga, gb}), (1 << (NA + NB)) - 1);
      pa = ga;
      pb = gb;
      @(negedge clk);
      #5;
      if (fast) check(ga == '0, "R5 low phase", int'(ga), 0);
      #4;
      // R9: nothing moves between rising edges
      check(gb == pb, "R9 stable between edges", int'(gb), int'(pb));
      if (!fast) check(ga == pa, "R9 stable between edges", int'(ga), int'(pa));
    end
  endtask

  task automatic t_hold();
    start(1'b0, 1'b1);
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk);
      #5;
      if (run_m) eff++;
      check_outputs("R7 hold and resume");
      hold = ((k >= 8) && (k < 15)) || ((k >= 20) && (k < 23)) || (k == 30);
    end
    hold = 1'b0;
  endtask

  task automatic t_runt();
    start(1'b1, 1'b0);
    mon_on = 1'b1;
    for (int k = 1; k <= 60; k++) begin
      @(posedge clk);
      #5;
      if (run_m) eff++;
      check_outputs("R8 R5 R6 hold toggling");
      #(((k * 7) % 13) + 1);
      if ((k % 3) != 1) hold = ~hold;
    end
    @(posedge clk);
    mon_on = 1'b0;
    hold = 1'b0;
    check(runts == 0, "R8 short pulse count", runts, 0);
  endtask

  task automatic t_reset();
    start(1'b0, 1'b0);
    repeat (5) @(posedge clk);
    #5;
    rst = 1'b1;
    #1;
    check(ga == '0 && gb == '0, "R1 immediate reset", int'({ga, gb}), 0);
    hold = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #5;
      check(ga == '0 && gb == '0, "R1 held in reset", int'({ga, gb}), 0);
      hold = ~hold;
    end
    start(1'b1, 1'b1);
    @(posedge clk);
    #5;
    check(ga == '1, "R5 pass-through high", int'(ga), (1 << NA) - 1);
    rst = 1'b1;
    #1;
    check(ga == '0 && gb == '0, "R1 reset cuts pass-through", int'({ga, gb}), 0);
  endtask

  initial begin
    #1;
    check(ga == '0 && gb == '0, "R1 reset state", int'({ga, gb}), 0);
    t_modes(1'b0, 1'b0, "R3 R4 div2 div4");
    t_modes(1'b0, 1'b1, "R3 R4 div2 div6");
    t_modes(1'b1, 1'b0, "R5 R6 div1 div2");
    t_modes(1'b1, 1'b1, "R5 R6 div1 div3");
    t_hold();
    t_runt();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule